// File: doc/BRIEF.md
# Step-commanded I2C bus master

This block is a single-master I2C engine that software drives one bus step at a time. A one-cycle command pulse asks for one of four steps: a Start condition, a Stop condition, an 8-bit transmit or an 8-bit receive. A Start issued while the bus is already held becomes a Repeated Start. When the step ends, the block raises a sticky interrupt flag. The block never moves on to the next step by itself. Software decides every address byte, data byte, acknowledge policy and bus release.

The block generates every SCL pulse. It drives SCL and SDA as open-drain enables, where 1 pulls the line low and 0 releases it high. It reads the SDA line back to capture received data and the slave's acknowledge. One bus bit lasts four quarter periods. Each quarter period lasts `baud_reload + 1` system clocks, so the `baud_reload` input sets the SCL rate, for example 100 kHz, 400 kHz or 1 MHz. The first byte after a Start is normally a 7-bit slave address followed by a direction bit: 0 for a master write and 1 for a master read. The block shifts that byte out like any other transmit byte.

Top module: `i2c_step_master`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `busy`, `irq`, `wcol`, `ack_rcvd` and `rx_data` are all 0, and the bus is not owned.
- R2: A Start accepted while the bus is free releases both lines and then pulls SDA low while SCL stays high. It then pulls SCL low. `irq` rises 4 × (`baud_reload`+1) clocks after the clock edge that accepts the command. The bus is then owned, with SCL held low.
- R3: A Start accepted while the bus is owned is a Repeated Start. It releases SDA with SCL low, releases SCL, then pulls SDA low while SCL is high. No Stop appears on the bus. Afterwards the bus stays owned with SCL held low. The timing matches R2.
- R4: A transmit command (`cmd_write`) sends `tx_data` MSB first on eight SCL pulses. On the ninth pulse it releases SDA and samples the line into `ack_rcvd` (0 = ACK, 1 = NACK). `irq` rises 36 × (`baud_reload`+1) clocks after the accepting edge, with SCL left low.
- R5: A receive command (`cmd_read`) clocks eight bits from SDA, MSB first, into `rx_data`. On the ninth pulse it drives the `ack_bit` value that was captured with the command (0 pulls SDA low = ACK, 1 releases it = NACK). The timing matches R4.
- R6: A Stop command pulls SDA low while SCL is low, releases SCL, and then releases SDA while SCL is high. Both lines end released and the bus is no longer owned. `irq` rises 4 × (`baud_reload`+1) clocks after the accepting edge.
- R7: During a transmit or receive, SDA changes only while SCL is driven low. SDA changes while SCL is high only for a Start or a Stop.
- R8: `busy` is 1 from the clock after a command is accepted until the edge at which that step sets `irq`.
- R9: A command that arrives while `busy` is 1 is ignored and sets `wcol`. A Stop, transmit or receive command that arrives while the bus is not owned is also ignored and sets `wcol`. An ignored command leaves `busy` at 0 if it was 0, and leaves the running step and the bus lines unchanged.
- R10: `irq` and `wcol` stay at 1 until `flag_clr` is pulsed. A new setting on the same edge as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Pulse: Start, or Repeated Start when the bus is owned |
| cmd_stop | input | 1 | Pulse: Stop condition |
| cmd_write | input | 1 | Pulse: transmit `tx_data` |
| cmd_read | input | 1 | Pulse: receive one byte |
| tx_data | input | 8 | Byte to transmit, captured with `cmd_write` |
| ack_bit | input | 1 | Acknowledge to drive after a received byte (0 = ACK), captured with `cmd_read` |
| flag_clr | input | 1 | Clears `irq` and `wcol` |
| baud_reload | input | DIV_W | Quarter-bit length minus one, in clocks |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| rx_data | output | 8 | Last received byte |
| ack_rcvd | output | 1 | Acknowledge sampled after the last transmit (1 = NACK) |
| busy | output | 1 | A step is in progress |
| irq | output | 1 | Sticky step-complete flag |
| wcol | output | 1 | Sticky ignored-command flag |

## Verification
The assertions check these rules on every cycle:
- SDA stays quiet while SCL is high during a byte.
- SDA may fall with SCL high only during a Start, and may rise with SCL high only during a Stop.
- An idle, unowned bus is fully released, and an idle, owned bus keeps SCL low.
- Every fall of `busy` comes with `irq`.
- A transmit command that arrives while busy always sets `wcol`.

Only the bench's slave model can show the other properties:
- The bits really travel MSB first in both directions.
- The slave's NACK lands in `ack_rcvd`, and the master's chosen acknowledge reaches the slave.
- A Repeated Start is seen on the bus as a Start with no Stop before it.
- Each step takes exactly its quarter-count times `baud_reload`+1 clocks.

// File: rtl/i2c_step_pkg.sv
package i2c_step_pkg;

    localparam int BYTE_W  = 8;
    localparam int BITN_W  = 4;
    localparam logic [BITN_W-1:0] ACK_SLOT = 4'd8;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_START = 3'd1,
        OP_STOP  = 3'd2,
        OP_WRITE = 3'd3,
        OP_READ  = 3'd4
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [BITN_W-1:0] bitn;
        logic [1:0]        qtr;
        logic [BYTE_W-1:0] shreg;
        logic [BYTE_W-1:0] rx;
        logic              ack_rx;
        logic              ackd;
        logic              scl_oe;
        logic              sda_oe;
        logic              owned;
        logic              irq;
        logic              wcol;
    } seq_state_t;

endpackage

// File: rtl/i2c_step_baud.sv
module i2c_step_baud #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] reload,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == reload) begin
            cnt_d = '0;
            tick  = 1'b1;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/i2c_step_seq.sv
module i2c_step_seq
    import i2c_step_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              cmd_write,
    input  logic              cmd_read,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              ack_bit,
    input  logic              flag_clr,
    input  logic              tick,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] rx_data,
    output logic              ack_rcvd,
    output logic              busy,
    output logic              irq,
    output logic              wcol,
    output logic              owned,
    output op_e               cur_op
);

    seq_state_t q, d;
    op_e        nop;
    logic       any_cmd;

    // Line pattern {scl_oe, sda_oe} for quarter qn of the current bit.
    function automatic logic [1:0] line_pat(op_e op, logic [BITN_W-1:0] bitn,
                                            logic [1:0] qn, logic rs,
                                            logic txb, logic ackd);
        logic [1:0] r;
        r = 2'b00;
        case (op)
            OP_START: begin
                case (qn)
                    2'd0:    r = {rs, 1'b0};
                    2'd1:    r = 2'b00;
                    2'd2:    r = 2'b01;
                    default: r = 2'b11;
                endcase
            end
            OP_STOP: begin
                case (qn)
                    2'd0:    r = 2'b11;
                    2'd3:    r = 2'b00;
                    default: r = 2'b01;
                endcase
            end
            OP_WRITE: r = {qn < 2'd2, (bitn < ACK_SLOT) ? ~txb : 1'b0};
            OP_READ:  r = {qn < 2'd2, (bitn == ACK_SLOT) ? ~ackd : 1'b0};
            default:  r = 2'b00;
        endcase
        return r;
    endfunction

    assign any_cmd = cmd_start | cmd_stop | cmd_write | cmd_read;

    always_comb begin
        d      = q;
        d.irq  = q.irq  & ~flag_clr;
        d.wcol = q.wcol & ~flag_clr;

        // Acceptance, priority start > stop > write > read.
        nop = OP_NONE;
        if (q.op == OP_NONE) begin
            if (cmd_start)                nop = OP_START;
            else if (q.owned && cmd_stop)  nop = OP_STOP;
            else if (q.owned && cmd_write) nop = OP_WRITE;
            else if (q.owned && cmd_read)  nop = OP_READ;
        end

        if (nop != OP_NONE) begin
            d.op   = nop;
            d.bitn = '0;
            d.qtr  = 2'd0;
            if (nop == OP_WRITE) d.shreg = tx_data;
            if (nop == OP_READ)  d.ackd  = ack_bit;
            if (nop == OP_START || nop == OP_STOP)
                {d.scl_oe, d.sda_oe} = line_pat(nop, '0, 2'd0, q.owned, 1'b0, 1'b0);
            else
                d.scl_oe = 1'b1;
        end else begin
            if (any_cmd) d.wcol = 1'b1;
            if (q.op != OP_NONE && tick) begin
                if (q.qtr == 2'd2) begin
                    if (q.op == OP_READ && q.bitn < ACK_SLOT)
                        d.rx = {q.rx[BYTE_W-2:0], sda_in};
                    if (q.op == OP_WRITE && q.bitn == ACK_SLOT)
                        d.ack_rx = sda_in;
                end
                if (q.qtr == 2'd3) begin
                    if (q.op == OP_START || q.op == OP_STOP || q.bitn == ACK_SLOT) begin
                        d.op    = OP_NONE;
                        d.irq   = 1'b1;
                        d.owned = (q.op != OP_STOP);
                        if (q.op == OP_WRITE || q.op == OP_READ) d.scl_oe = 1'b1;
                    end else begin
                        d.bitn   = q.bitn + 1'b1;
                        d.qtr    = 2'd0;
                        d.scl_oe = 1'b1;
                        if (q.op == OP_WRITE) d.shreg = {q.shreg[BYTE_W-2:0], 1'b0};
                    end
                end else begin
                    d.qtr = q.qtr + 2'd1;
                    {d.scl_oe, d.sda_oe} = line_pat(q.op, q.bitn, q.qtr + 2'd1,
                                                    q.owned, q.shreg[BYTE_W-1], q.ackd);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign scl_oe   = q.scl_oe;
    assign sda_oe   = q.sda_oe;
    assign rx_data  = q.rx;
    assign ack_rcvd = q.ack_rx;
    assign busy     = (q.op != OP_NONE);
    assign irq      = q.irq;
    assign wcol     = q.wcol;
    assign owned    = q.owned;
    assign cur_op   = q.op;

endmodule

// File: rtl/i2c_step_master.sv
module i2c_step_master
    import i2c_step_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              cmd_write,
    input  logic              cmd_read,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              ack_bit,
    input  logic              flag_clr,
    input  logic [DIV_W-1:0]  baud_reload,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] rx_data,
    output logic              ack_rcvd,
    output logic              busy,
    output logic              irq,
    output logic              wcol
);

    logic tick;
    logic bus_owned;
    op_e  cur_op;

    i2c_step_baud #(.DIV_W(DIV_W)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy),
        .reload (baud_reload),
        .tick   (tick)
    );

    i2c_step_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .cmd_write (cmd_write),
        .cmd_read  (cmd_read),
        .tx_data   (tx_data),
        .ack_bit   (ack_bit),
        .flag_clr  (flag_clr),
        .tick      (tick),
        .sda_in    (sda_in),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .rx_data   (rx_data),
        .ack_rcvd  (ack_rcvd),
        .busy      (busy),
        .irq       (irq),
        .wcol      (wcol),
        .owned     (bus_owned),
        .cur_op    (cur_op)
    );

endmodule

// File: rtl/i2c_step_master_chk.sv
module i2c_step_master_chk
    import i2c_step_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic irq,
    input logic wcol,
    input logic scl_oe,
    input logic sda_oe,
    input logic owned,
    input logic cmd_write,
    input op_e  op
);

    logic in_byte;
    assign in_byte = (op == OP_WRITE) || (op == OP_READ);

    AST_SDA_QUIET_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        in_byte && $past(in_byte) && !scl_oe && !$past(scl_oe) |-> $stable(sda_oe)); // R7

    AST_SDA_FALL_IS_START: assert property (@(posedge clk) disable iff (!rst_n)
        !scl_oe && !$past(scl_oe) && $rose(sda_oe) |-> op == OP_START); // R2

    AST_SDA_RISE_IS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !scl_oe && !$past(scl_oe) && $fell(sda_oe) |-> op == OP_STOP); // R6

    AST_FREE_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !owned |-> !scl_oe && !sda_oe); // R6

    AST_HELD_BUS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && owned |-> scl_oe); // R3

    AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq); // R8

    AST_BUSY_CMD_COLLIDES: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cmd_write |=> wcol); // R9

endmodule

bind i2c_step_master i2c_step_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .irq       (irq),
    .wcol      (wcol),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .owned     (bus_owned),
    .cmd_write (cmd_write),
    .op        (cur_op)
);

// File: tb/i2c_step_master_bench.sv
module i2c_step_master_bench;

    localparam int DIV_W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 0, cmd_stop = 0, cmd_write = 0, cmd_read = 0;
    logic [7:0] tx_data = '0;
    logic ack_bit = 0, flag_clr = 0;
    logic [DIV_W-1:0] baud_reload = '0;
    logic scl_oe, sda_oe, ack_rcvd, busy, irq, wcol;
    logic [7:0] rx_data;

    // Slave model state
    int         slv_mode = 0;   // 0 silent, 1 receives and acks, 2 sends slv_byte
    logic       slv_nack = 0;
    logic [7:0] slv_byte = '0;
    logic [7:0] slv_rx = '0;
    logic       slv_ack_seen = 0;
    int         slv_idx = 0;
    logic       slv_rose = 0;
    int         n_starts = 0, n_stops = 0;
    logic       prev_scl = 1, prev_sda = 1;
    logic       slv_drive, scl_line, sda_line;

    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    assign slv_drive = (slv_mode == 1) ? (slv_idx == 8 && !slv_nack) :
                       (slv_mode == 2) ? (slv_idx < 8 && !slv_byte[3'(7 - slv_idx)]) : 1'b0;
    assign scl_line = ~scl_oe;
    assign sda_line = ~(sda_oe | slv_drive);

    i2c_step_master #(.DIV_W(DIV_W)) u_i2c_step_master (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .cmd_write(cmd_write), .cmd_read(cmd_read), .tx_data(tx_data),
        .ack_bit(ack_bit), .flag_clr(flag_clr), .baud_reload(baud_reload),
        .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_data(rx_data),
        .ack_rcvd(ack_rcvd), .busy(busy), .irq(irq), .wcol(wcol)
    );

    always @(posedge clk) begin
        prev_scl <= scl_line;
        prev_sda <= sda_line;
        if (scl_line && prev_scl && prev_sda && !sda_line) begin
            n_starts <= n_starts + 1;
            slv_idx  <= 0;
            slv_rose <= 0;
        end else if (scl_line && prev_scl && !prev_sda && sda_line) begin
            n_stops <= n_stops + 1;
        end else if (scl_line && !prev_scl) begin
            slv_rose <= 1;
            if (slv_idx < 8) slv_rx <= {slv_rx[6:0], sda_line};
            else             slv_ack_seen <= sda_line;
        end else if (!scl_line && prev_scl && slv_rose) begin
            slv_rose <= 0;
            slv_idx  <= (slv_idx == 8) ? 0 : slv_idx + 1;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_cycles(input int kind, input int r);
        return ((kind >= 2) ? 36 : 4) * (r + 1) + 1;
    endfunction

    task automatic clear_flags();
        @(negedge clk) flag_clr = 1;
        @(negedge clk) flag_clr = 0;
    endtask

    // kind: 0 start, 1 stop, 2 write, 3 read
    task automatic do_cmd(input int kind, input logic [7:0] d, input logic ab,
                          input bit collide, output int n);
        @(negedge clk);
        tx_data = d; ack_bit = ab;
        cmd_start = (kind == 0); cmd_stop = (kind == 1);
        cmd_write = (kind == 2); cmd_read = (kind == 3);
        @(posedge clk); n = 1;
        @(negedge clk);
        cmd_start = 0; cmd_stop = 0; cmd_write = 0; cmd_read = 0;
        while (!irq && n < 4000) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (collide) begin
                if (n == 5) begin
                    chk(busy == 1'b1, "R8 busy mid-step", int'(busy), 1);
                    cmd_write = 1; tx_data = ~d;
                end else begin
                    cmd_write = 0;
                end
            end
        end
    endtask

    task automatic step_start(input int r, input string req);
        int n, s0;
        s0 = n_starts; slv_mode = 0;
        do_cmd(0, 8'h00, 1'b0, 0, n);
        chk(n == exp_cycles(0, r), {req, " start timing"}, n, exp_cycles(0, r));
        chk(n_starts == s0 + 1, {req, " start seen"}, n_starts, s0 + 1);
        chk(scl_oe == 1'b1, {req, " SCL held"}, int'(scl_oe), 1);
        clear_flags();
    endtask

    task automatic step_write(input int r, input logic [7:0] d, input logic nack, input bit collide);
        int n;
        slv_mode = 1; slv_nack = nack;
        do_cmd(2, d, 1'b0, collide, n);
        chk(n == exp_cycles(2, r), "R4 write timing", n, exp_cycles(2, r));
        chk(slv_rx == d, "R4 byte at slave", int'(slv_rx), int'(d));
        chk(ack_rcvd == nack, "R4 ack captured", int'(ack_rcvd), int'(nack));
        if (collide) chk(wcol == 1'b1, "R9 busy collision", int'(wcol), 1);
        clear_flags();
    endtask

    task automatic step_read(input int r, input logic [7:0] d, input logic ab);
        int n;
        slv_mode = 2; slv_byte = d;
        do_cmd(3, 8'h00, ab, 0, n);
        chk(n == exp_cycles(3, r), "R5 read timing", n, exp_cycles(3, r));
        chk(rx_data == d, "R5 received byte", int'(rx_data), int'(d));
        chk(slv_ack_seen == ab, "R5 master ack", int'(slv_ack_seen), int'(ab));
        slv_mode = 0;
        clear_flags();
    endtask

    task automatic step_stop(input int r);
        int n, p0;
        p0 = n_stops; slv_mode = 0;
        do_cmd(1, 8'h00, 1'b0, 0, n);
        chk(n == exp_cycles(1, r), "R6 stop timing", n, exp_cycles(1, r));
        chk(n_stops == p0 + 1, "R6 stop seen", n_stops, p0 + 1);
        chk(!scl_oe && !sda_oe, "R6 lines released", int'({scl_oe, sda_oe}), 0);
        clear_flags();
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int n, p0, s0, r, nb;
        logic [7:0] d;
        logic rw, nk;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk({scl_oe, sda_oe, busy, irq, wcol, ack_rcvd} == 6'b0 && rx_data == 8'h00,
            "R1 reset outputs", int'({scl_oe, sda_oe, busy, irq, wcol}), 0);

        // R9 write while bus not owned is ignored
        baud_reload = 10'd1;
        @(negedge clk) cmd_write = 1; tx_data = 8'hA5;
        @(negedge clk) cmd_write = 0;
        chk(busy == 1'b0, "R9 unowned write ignored", int'(busy), 0);
        chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R9 lines untouched", int'({scl_oe, sda_oe}), 0);
        chk(wcol == 1'b1, "R9 unowned wcol", int'(wcol), 1);
        repeat (5) @(negedge clk);
        chk(wcol == 1'b1, "R10 wcol sticky", int'(wcol), 1);
        clear_flags();
        chk(wcol == 1'b0, "R10 wcol cleared", int'(wcol), 0);

        // R2 start from free bus, irq sticky
        s0 = n_starts; slv_mode = 0;
        do_cmd(0, 8'h00, 1'b0, 0, n);
        chk(n == exp_cycles(0, 1), "R2 start timing", n, exp_cycles(0, 1));
        chk(n_starts == s0 + 1, "R2 start seen", n_starts, s0 + 1);
        chk(scl_oe == 1'b1 && busy == 1'b0, "R2 bus held idle", int'({scl_oe, busy}), 2);
        repeat (6) @(negedge clk);
        chk(irq == 1'b1, "R10 irq sticky", int'(irq), 1);
        clear_flags();
        chk(irq == 1'b0, "R10 irq cleared", int'(irq), 0);

        // R4 writes with ACK, with collision, and with NACK
        step_write(1, 8'hA4, 1'b0, 1);
        step_write(1, 8'h3C, 1'b1, 0);

        // R3 repeated start: no stop in between
        p0 = n_stops;
        step_start(1, "R3");
        chk(n_stops == p0, "R3 no stop before restart", n_stops, p0);

        // R5 reads with ACK then NACK
        step_write(1, 8'hA5, 1'b0, 0);
        step_read(1, 8'h5B, 1'b0);
        step_read(1, 8'hC3, 1'b1);

        // R6 stop, then R9 read on free bus ignored
        step_stop(1);
        @(negedge clk) cmd_read = 1;
        @(negedge clk) cmd_read = 0;
        chk(busy == 1'b0 && wcol == 1'b1, "R9 unowned read ignored", int'({busy, wcol}), 1);
        chk(scl_oe == 1'b0, "R9 read left SCL free", int'(scl_oe), 0);
        clear_flags();

        // Random transactions at several divider settings
        for (int t = 0; t < 16; t++) begin
            r = $urandom % 4;
            @(negedge clk) baud_reload = DIV_W'(r);
            step_start(r, "R2");
            rw = 1'($urandom);
            nk = 1'(($urandom % 5) == 0);
            step_write(r, {7'($urandom), rw}, nk, 0);
            nb = 1 + $urandom % 2;
            if (!nk) begin
                for (int b = 0; b < nb; b++) begin
                    d = 8'($urandom);
                    if (rw) step_read(r, d, (b == nb - 1));
                    else    step_write(r, d, 1'b0, 0);
                end
            end
            if (($urandom % 3) == 0) begin
                p0 = n_stops;
                step_start(r, "R3");
                chk(n_stops == p0, "R3 restart without stop", n_stops, p0);
            end
            step_stop(r);
        end

        finish_run();
    end

endmodule